// File: doc/BRIEF.md
# MAC Interrupt Status and Reset Controller

This block is the register-side control of an Ethernet MAC. It holds the command register, the interrupt enable register, the interrupt status register and a small set of configuration registers. Software reaches all of them over a simple 32-bit word-addressed read/write bus. The transmit and receive engines report events to the block as one-cycle pulses. Each pulse latches a status bit, and software clears the bit by writing a one to it.

The status word is split into two halves. The upper sixteen bits, masked by the matching enable bits, drive the transmit interrupt line. The lower sixteen bits drive the receive interrupt line in the same way. Setting bit 24 of the command register starts a software reset of fixed length. While it runs, the block holds every register at its reset value, reads back zero, ignores bus writes and engine events, and holds a reset output to the engines high. Bit 24 clears itself when the reset ends.

Top module: `mac_ctl_top`

## Requirements
- R1: Word offsets are 0 command, 1 enable, 2 status, 3 FIFO threshold, 4 receive frame limit, 5 MII data/address, 6 missed-packet counter, 7 transmit list start and 8 receive list start. Read data appears on bus_rdata one clock edge after the cycle in which bus_rd is high. Any other offset reads 0.
- R2: After a hardware reset the registers read as follows: FIFO threshold 0x00000101, frame limit 0x00000800, MII 0x00900000, missed counter 0x00007FFF, both list starts 0xFFFFFFFC. Every other register reads 0, and both interrupt lines and eng_rst_o are low.
- R3: A pulse on tx_event[i] sets status bit 16+i, and a pulse on rx_event[i] sets status bit i. Only status bits 24, 23, 18 and 16 (transmit) and 11, 10, 9, 8, 4, 3 and 0 (receive) exist. The other bits stay 0, so all-ones events give 0x01850F19.
- R4: Writing the status register clears each bit written as 1 and leaves the others. Writing 0xFFFF0000 clears only the transmit bits.
- R5: An event that arrives in the same cycle as a write-one-to-clear of its bit leaves that bit set.
- R6: The enable register keeps only bits 18, 16, 4 and 0. Writing all ones reads back 0x00050011.
- R7: tx_irq_o is the OR of status[31:16] AND enable[31:16], and rx_irq_o is the same for bits [15:0]. Both follow the registers without added delay.
- R8: Writing the command register with bit 24 set raises eng_rst_o for exactly 16 cycles. Afterwards the command register reads back 0. Other command bits appear on cmd_o.
- R9: While eng_rst_o is high, reads return 0, bus writes and engine events have no effect, and both interrupt lines are low.
- R10: When the software reset ends, every register holds its R2 value again.
- R11: The two list start registers ignore written bits 1:0, which read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (4) | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_event | input | 16 | Transmit event pulses, bit i maps to status bit 16+i |
| rx_event | input | 16 | Receive event pulses, bit i maps to status bit i |
| cmd_o | output | 32 | Command register contents |
| eng_rst_o | output | 1 | Reset to the data engines during a software reset |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
A register write or an event pulse changes state at the next clock edge, and the interrupt lines follow in that same cycle. The bench therefore checks the interrupt lines at the falling edge after the pulse or write. Read data is due one edge after the read strobe. The driver queues the expected word when it raises bus_rd, and the monitor pops and compares it just after that rising edge. The software reset window is measured by counting the falling edges at which eng_rst_o is high, starting right after the command write, and the count must be 16.

// File: rtl/mac_ctl_pkg.sv
package mac_ctl_pkg;
  localparam int DW = 32;

  localparam int OFS_CMD  = 0;
  localparam int OFS_IEN  = 1;
  localparam int OFS_ISR  = 2;
  localparam int OFS_CFG0 = 3;
  localparam int NCFG     = 6;

  localparam int SRST_BIT = 24;

  // implemented status bits: tx 24,23,18,16 / rx 11,10,9,8,4,3,0
  localparam logic [DW-1:0] ISR_IMPL = 32'h0185_0F19;
  // implemented enable bits: 18,16,4,0
  localparam logic [DW-1:0] IEN_IMPL = 32'h0005_0011;

  function automatic logic [DW-1:0] cfg_rst(input int idx);
    case (idx)
      0:       cfg_rst = 32'h0000_0101;
      1:       cfg_rst = 32'h0000_0800;
      2:       cfg_rst = 32'h0090_0000;
      3:       cfg_rst = 32'h0000_7FFF;
      4:       cfg_rst = 32'hFFFF_FFFC;
      5:       cfg_rst = 32'hFFFF_FFFC;
      default: cfg_rst = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] cfg_mask(input int idx);
    if (idx == 4 || idx == 5) cfg_mask = 32'hFFFF_FFFC;
    else                      cfg_mask = 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/mac_ctl_srst.sv
module mac_ctl_srst
  import mac_ctl_pkg::*;
#(
  parameter int SRST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_o,
  output logic          start_o,
  output logic          busy_o
);
  localparam int CW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SRST_CYCLES - 1);

  logic [DW-1:0] cmd_q, cmd_d;
  logic          cmd_en;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign start_o = wr_cmd && wdata[SRST_BIT] && !busy_q;

  always_comb begin
    cmd_en = wr_cmd || busy_q;
    cmd_d  = cmd_q;
    if (start_o || busy_q) cmd_d = '0;
    else if (wr_cmd)       cmd_d = wdata & ~(DW'(1) << SRST_BIT);
  end

  always_comb begin
    cnt_en = start_o || busy_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_d = 1'b0;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cmd_en) cmd_q  <= cmd_d;
      if (cnt_en) begin
        busy_q <= busy_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/mac_ctl_isr.sv
module mac_ctl_isr
  import mac_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          wr_isr,
  input  logic          wr_ien,
  input  logic [DW-1:0] wdata,
  input  logic [15:0]   tx_event,
  input  logic [15:0]   rx_event,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] enable_o,
  output logic          tx_irq_o,
  output logic          rx_irq_o
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] status_q, status_d, enable_q, enable_d, evt, clr;
  logic          status_en, enable_en;
  logic [1:0]    irq_vec;

  always_comb begin
    evt       = {tx_event, rx_event} & ISR_IMPL;
    clr       = wr_isr ? wdata : '0;
    status_en = soft_clr || wr_isr || (|evt);
    // new events override a simultaneous clear
    status_d  = soft_clr ? '0 : ((status_q & ~clr) | evt);
    enable_en = soft_clr || wr_ien;
    enable_d  = soft_clr ? '0 : (wdata & IEN_IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      if (status_en) status_q <= status_d;
      if (enable_en) enable_q <= enable_d;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_line
    assign irq_vec[h] = |(status_q[h*HALF +: HALF] & enable_q[h*HALF +: HALF]);
  end

  assign tx_irq_o = irq_vec[1];
  assign rx_irq_o = irq_vec[0];
  assign status_o = status_q;
  assign enable_o = enable_q;
endmodule

// File: rtl/mac_ctl_cfg.sv
module mac_ctl_cfg
  import mac_ctl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_clr,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [NCFG-1:0][DW-1:0]  val_o
);
  for (genvar g = 0; g < NCFG; g++) begin : g_reg
    localparam logic [DW-1:0] RVAL = cfg_rst(g);
    localparam logic [DW-1:0] MASK = cfg_mask(g);
    logic [DW-1:0] q, d;
    logic          en, hit;

    always_comb begin
      hit = wr_en && (addr == AW'(OFS_CFG0 + g));
      en  = soft_clr || hit;
      d   = soft_clr ? RVAL : (wdata & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RVAL;
      else if (en) q <= d;
    end

    assign val_o[g] = q;
  end
endmodule

// File: rtl/mac_ctl_top.sv
module mac_ctl_top
  import mac_ctl_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SRST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [15:0]   tx_event,
  input  logic [15:0]   rx_event,
  output logic [DW-1:0] cmd_o,
  output logic          eng_rst_o,
  output logic          tx_irq_o,
  output logic          rx_irq_o
);
  logic [1:0] sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_s = sync_q[1];

  logic                    srst_start, srst_busy, soft_clr, wr_ok;
  logic [DW-1:0]           isr_status, ien_val;
  logic [NCFG-1:0][DW-1:0] cfg_val;
  logic [15:0]             tx_ev_g, rx_ev_g;

  assign wr_ok    = bus_wr && !srst_busy;
  assign soft_clr = srst_start || srst_busy;
  assign tx_ev_g  = srst_busy ? '0 : tx_event;
  assign rx_ev_g  = srst_busy ? '0 : rx_event;

  mac_ctl_srst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_cmd  (wr_ok && (bus_addr == AW'(OFS_CMD))),
    .wdata   (bus_wdata),
    .cmd_o   (cmd_o),
    .start_o (srst_start),
    .busy_o  (srst_busy)
  );

  mac_ctl_isr u_isr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .soft_clr (soft_clr),
    .wr_isr   (wr_ok && (bus_addr == AW'(OFS_ISR))),
    .wr_ien   (wr_ok && (bus_addr == AW'(OFS_IEN))),
    .wdata    (bus_wdata),
    .tx_event (tx_ev_g),
    .rx_event (rx_ev_g),
    .status_o (isr_status),
    .enable_o (ien_val),
    .tx_irq_o (tx_irq_o),
    .rx_irq_o (rx_irq_o)
  );

  mac_ctl_cfg #(.AW(AW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .soft_clr (soft_clr),
    .wr_en    (wr_ok),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .val_o    (cfg_val)
  );

  logic [DW-1:0] rd_mux, rdata_q, rdata_d;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_CMD))      rd_mux = cmd_o;
    else if (bus_addr == AW'(OFS_IEN)) rd_mux = ien_val;
    else if (bus_addr == AW'(OFS_ISR)) rd_mux = isr_status;
    else begin
      for (int i = 0; i < NCFG; i++)
        if (bus_addr == AW'(OFS_CFG0 + i)) rd_mux = cfg_val[i];
    end
    rdata_d = srst_busy ? '0 : rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign eng_rst_o = srst_busy;
endmodule

// File: rtl/mac_ctl_chk.sv
module mac_ctl_chk #(
  parameter int AW          = 4,
  parameter int SRST_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [15:0]   rx_event,
  input logic          eng_rst_o,
  input logic          tx_irq_o,
  input logic          rx_irq_o,
  input logic [31:0]   status
);
  logic [15:0] busy_cnt;
  logic        srst_wr, isr16_wr;

  assign srst_wr  = bus_wr && (bus_addr == AW'(0)) && bus_wdata[24];
  assign isr16_wr = bus_wr && (bus_addr == AW'(2)) && bus_wdata[16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (eng_rst_o) busy_cnt <= busy_cnt + 16'd1;
    else                busy_cnt <= '0;
  end

  // R8: engine reset only follows a command write with bit 24
  assert_rst_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rst_o) |-> $past(srst_wr));

  // R8: reset window length
  assert_rst_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_rst_o) |-> (busy_cnt == 16'(SRST_CYCLES)));

  // R9: interrupts quiet during the reset
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst_o |-> (!tx_irq_o && !rx_irq_o));

  // R9: reads during the reset return zero
  assert_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rst_o && bus_rd) |=> (bus_rdata == 32'h0));

  // R5: an event always lands, even against a clear
  assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_event[0] && !eng_rst_o && !srst_wr) |=> status[0]);

  // R4: a status bit only drops on a clear write or a soft reset
  assert_clear_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[16]) |-> ($past(isr16_wr) || $past(srst_wr) || $past(eng_rst_o)));
endmodule

bind mac_ctl_top mac_ctl_chk #(.AW(AW), .SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rx_event  (rx_event),
  .eng_rst_o (eng_rst_o),
  .tx_irq_o  (tx_irq_o),
  .rx_irq_o  (rx_irq_o),
  .status    (isr_status)
);

// File: tb/mac_ctl_top_tb.sv
`timescale 1ns/1ps
module mac_ctl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, cmd_o;
  logic [15:0] tx_event = '0, rx_event = '0;
  logic        eng_rst_o, tx_irq_o, rx_irq_o;

  always #5 clk = ~clk;

  mac_ctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_event(tx_event), .rx_event(rx_event), .cmd_o(cmd_o),
    .eng_rst_o(eng_rst_o), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: read data due one edge after bus_rd
  always @(posedge clk) begin
    if (bus_rd) begin
      #1;
      if (exp_q.size() == 0) check("R1 queue", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ev(input logic [15:0] t, input logic [15:0] r);
    @(negedge clk);
    tx_event = t; rx_event = r;
    @(negedge clk);
    tx_event = '0; rx_event = '0;
  endtask

  task automatic rd_defaults(input string tag);
    rd(4'd0, 32'h0000_0000, {tag, " cmd"});
    rd(4'd1, 32'h0000_0000, {tag, " ien"});
    rd(4'd2, 32'h0000_0000, {tag, " isr"});
    rd(4'd3, 32'h0000_0101, {tag, " fifo"});
    rd(4'd4, 32'h0000_0800, {tag, " rxlim"});
    rd(4'd5, 32'h0090_0000, {tag, " mii"});
    rd(4'd6, 32'h0000_7FFF, {tag, " missed"});
    rd(4'd7, 32'hFFFF_FFFC, {tag, " txlist"});
    rd(4'd8, 32'hFFFF_FFFC, {tag, " rxlist"});
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R2 irq/eng_rst idle", {29'd0, tx_irq_o, rx_irq_o, eng_rst_o}, 32'h0);
    rd_defaults("R2");
    rd(4'd12, 32'h0, "R1 unmapped");

    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h0005_0011, "R6 enable bits");
    wr(4'd1, 32'h0);

    ev(16'hFFFF, 16'hFFFF);
    rd(4'd2, 32'h0185_0F19, "R3 status bits");
    check("R7 masked off", {30'd0, tx_irq_o, rx_irq_o}, 32'h0);
    wr(4'd1, 32'h0004_0000);
    check("R7 tx line", {30'd0, tx_irq_o, rx_irq_o}, 32'h2);

    wr(4'd2, 32'hFFFF_0000);
    rd(4'd2, 32'h0000_0F19, "R4 upper clear");
    check("R7 tx drops", {30'd0, tx_irq_o, rx_irq_o}, 32'h0);

    wr(4'd1, 32'h0000_0010);
    check("R7 rx line", {30'd0, tx_irq_o, rx_irq_o}, 32'h1);
    wr(4'd2, 32'h0000_0010);
    rd(4'd2, 32'h0000_0F09, "R4 single clear");
    check("R7 rx drops", {30'd0, tx_irq_o, rx_irq_o}, 32'h0);

    // R5: event and clear of bit 0 in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h0000_0001; rx_event = 16'h0001;
    @(negedge clk);
    bus_wr = 1'b0; rx_event = '0;
    rd(4'd2, 32'h0000_0F09, "R5 event wins");
    wr(4'd2, 32'h0000_0F09);
    rd(4'd2, 32'h0, "R4 all cleared");

    wr(4'd3, 32'h1234_5678);
    rd(4'd3, 32'h1234_5678, "R1 fifo write");
    wr(4'd7, 32'h0000_1003);
    rd(4'd7, 32'h0000_1000, "R11 txlist low bits");
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, 32'hFFFF_FFFC, "R11 rxlist low bits");
    wr(4'd0, 32'h0000_0101);
    check("R8 cmd_o", cmd_o, 32'h0000_0101);

    // R8: reset window
    ev(16'h0004, 16'h0010);
    wr(4'd1, 32'h0005_0011);
    wr(4'd0, 32'h0100_0101);
    n = 0;
    while (eng_rst_o && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R8 reset length", 32'(n), 32'd16);
    rd_defaults("R10");
    check("R10 irq after reset", {30'd0, tx_irq_o, rx_irq_o}, 32'h0);

    // R9: accesses during reset
    wr(4'd3, 32'h0000_5555);
    wr(4'd0, 32'h0100_0000);
    rd(4'd3, 32'h0, "R9 read zero");
    wr(4'd3, 32'hAAAA_AAAA);
    ev(16'h0004, 16'h0001);
    check("R9 irq low", {30'd0, tx_irq_o, rx_irq_o}, 32'h0);
    while (eng_rst_o) @(negedge clk);
    rd(4'd3, 32'h0000_0101, "R9 write ignored");
    rd(4'd2, 32'h0, "R9 event ignored");
    rd(4'd0, 32'h0, "R8 self clear");
    check("R8 cmd_o cleared", cmd_o, 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule